// File: doc/BRIEF.md
# Crystal-Derived Time-of-Day Counter

This block turns a stream of 32.768 kHz enable pulses, sampled in a fast synchronous clock domain, into a one-second tick. It keeps the time of day as binary seconds, minutes and hours. The hour value always runs from 0 to 23. A display view is built from that stored time. It can show the hour in 24-hour or 12-hour form, and a mode input picks the form. Changing the mode alters only what is shown, never the count.

The display is assumed to be made of six latched digit cells, so they need no continuous repaint. On each second tick the block refreshes exactly one cell. It does this with a one-cycle strobe that carries the cell index and its BCD value, and the cell index steps round-robin through the six positions. All six BCD digits are also available in parallel for observation.

The prescaler width is a parameter. At the default of 16 bits, one tick needs 32 768 enables. A width of 1 turns every enable into a tick, which suits fast simulation of long spans.

Top module: `xtal_tod_core`

## Requirements
- R1: After reset, no tick appears until exactly 2^(PRE_W-1) cycles with `slow_en` high have been seen. At the default PRE_W=16 that is 32 768 enables. The tick and the seconds increment both appear in the cycle after the edge that sampled the last enable.
- R2: `sec_tick` is high for one cycle for each overflow, unless the next overflow falls in the very next cycle. The prescaler then restarts from its preload, so each later tick again needs 2^(PRE_W-1) enables.
- R3: Each tick increments `sec_bin`. When a tick arrives at 59 seconds, `sec_bin` returns to 0 and `min_bin` increments.
- R4: When a tick arrives at 59 minutes and 59 seconds, `min_bin` returns to 0 and `hr_bin` increments. Hours stay within 0..23, and 23:59:59 is followed by 00:00:00.
- R5: The binary time changes only on a tick. Toggling `hour12` never changes `sec_bin`, `min_bin` or `hr_bin`.
- R6: With `hour12`=0, the displayed hour equals `hr_bin`. With `hour12`=1, hour 0 shows as 12, hours 1..12 show unchanged, and hours 13..23 show as 1..11.
- R7: `disp_bcd[4*p+3:4*p]` holds BCD display position p. The positions are: 0 = hour tens, 1 = hour units, 2 = minute tens, 3 = minute units, 4 = second tens, 5 = second units. Leading zeros are shown as 0.
- R8: In the cycle after each tick, `dig_strobe` is high for one cycle. `dig_pos` holds the refresh index and `dig_bcd` holds that position's digit of the just-updated time. The index after reset is 0 and advances 0,1,2,3,4,5,0,... by one per tick. `dig_strobe` is never high in any other cycle.
- R9: A synchronous reset sets the time to 00:00:00, reloads the prescaler, clears both strobes and sets the refresh index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synchronous system clock |
| rst | input | 1 | Synchronous reset, active high |
| slow_en | input | 1 | One-cycle enable, one per 32.768 kHz period |
| hour12 | input | 1 | 1 selects the 12-hour display form, 0 selects 24-hour |
| sec_tick | output | 1 | One-cycle strobe per elapsed second |
| sec_bin | output | 6 | Binary seconds 0..59 |
| min_bin | output | 6 | Binary minutes 0..59 |
| hr_bin | output | 6 | Binary hours 0..23 |
| disp_bcd | output | 24 | Six BCD display digits, position p in bits 4p+3..4p |
| dig_strobe | output | 1 | One-cycle strobe for a display cell refresh |
| dig_pos | output | 3 | Display position being refreshed, 0..5 |
| dig_bcd | output | 4 | BCD value for the refreshed position |

## Verification
The assertions assume that `slow_en` is sampled as a plain level each clock. A run of consecutive high cycles therefore counts as that many enables, not as one. They also assume that reset is held for at least one edge before any time-dependent check becomes live, and that `hour12` may change in any cycle without reference to the tick. The stimulus drives every input on the falling clock edge. It holds `slow_en` high for exact cycle counts, or pulses it for single cycles with idle gaps, and it toggles the mode only while the enable is idle. This keeps each expected tick count exact and separates mode changes from time changes.

// File: rtl/tod_pkg.sv
package tod_pkg;
   localparam int NUM_POS    = 6;
   localparam int POS_W      = 3;
   localparam int FIELD_W    = 6;
   localparam int NUM_STAGES = 3;
   localparam int DISP_W     = 4 * NUM_POS;

   typedef logic [3:0] bcd_t;

   // modulus of each cascade stage: seconds, minutes, hours
   function automatic int stage_mod(input int idx);
      return (idx == NUM_STAGES - 1) ? 24 : 60;
   endfunction

   // two-digit BCD of a value below 100, packed {tens, units}
   function automatic logic [7:0] to_bcd2(input logic [FIELD_W-1:0] v);
      logic [FIELD_W-1:0] t;
      logic [FIELD_W-1:0] u;
      t = v / FIELD_W'(10);
      u = v % FIELD_W'(10);
      return {t[3:0], u[3:0]};
   endfunction
endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
   parameter int PRE_W = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic slow_en,
   output logic step,
   output logic tick
);
   generate
      if (PRE_W < 1 || PRE_W > 30) begin : g_bad_width
         initial $fatal(1, "tod_prescaler: PRE_W out of range");
      end
   endgenerate

   logic armed;
   always_ff @(posedge clk) armed <= !rst;

   generate
      if (PRE_W == 1) begin : g_direct
         // preload equals terminal count: every enable overflows
         assign step = slow_en;
      end else begin : g_count
         localparam logic [PRE_W-1:0] PRELOAD = PRE_W'(1 << (PRE_W - 1));
         logic [PRE_W-1:0] cnt;
         assign step = slow_en && (cnt == '1);
         always_ff @(posedge clk) begin
            if (rst)          cnt <= PRELOAD;
            else if (step)    cnt <= PRELOAD;
            else if (slow_en) cnt <= cnt + 1'b1;
         end
         assert_reload_R2: assert property (@(posedge clk) disable iff (rst || !armed)
            tick |-> (cnt == PRELOAD));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) tick <= 1'b0;
      else     tick <= step;
   end

   assert_tick_needs_en_R1: assert property (@(posedge clk) disable iff (rst || !armed)
      tick |-> $past(slow_en));
endmodule

// File: rtl/tod_modcnt.sv
module tod_modcnt #(
   parameter int MOD = 60,
   parameter int W   = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc,
   output logic [W-1:0] val,
   output logic         at_top
);
   localparam logic [W-1:0] TOP = W'(MOD - 1);

   generate
      if (MOD < 2 || MOD > (1 << W)) begin : g_bad_mod
         initial $fatal(1, "tod_modcnt: MOD does not fit W");
      end
   endgenerate

   assign at_top = (val == TOP);

   always_ff @(posedge clk) begin
      if (rst)      val <= '0;
      else if (inc) val <= at_top ? '0 : val + 1'b1;
   end

   assert_range_R4: assert property (@(posedge clk) disable iff (rst)
      val <= TOP);
endmodule

// File: rtl/tod_cascade.sv
module tod_cascade
   import tod_pkg::*;
(
   input  logic               clk,
   input  logic               rst,
   input  logic               step,
   output logic [FIELD_W-1:0] sec,
   output logic [FIELD_W-1:0] min,
   output logic [FIELD_W-1:0] hr
);
   logic [NUM_STAGES-1:0] carry;
   logic [NUM_STAGES-1:0] top;
   logic [FIELD_W-1:0]    val [NUM_STAGES];

   assign carry[0] = step;

   generate
      for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
         tod_modcnt #(.MOD(stage_mod(i)), .W(FIELD_W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .inc    (carry[i]),
            .val    (val[i]),
            .at_top (top[i])
         );
         if (i < NUM_STAGES - 1) begin : g_carry
            assign carry[i+1] = carry[i] & top[i];
         end
      end
   endgenerate

   assign sec = val[0];
   assign min = val[1];
   assign hr  = val[2];

   logic armed;
   always_ff @(posedge clk) armed <= !rst;

   assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (rst || !armed)
      ($past(step) && $past(sec) == 6'd59) |-> (sec == 6'd0));
   assert_min_inc_R3: assert property (@(posedge clk) disable iff (rst || !armed)
      ($past(step) && $past(sec) == 6'd59 && $past(min) != 6'd59) |-> (min == $past(min) + 6'd1));
   assert_day_wrap_R4: assert property (@(posedge clk) disable iff (rst || !armed)
      ($past(step) && $past(sec) == 6'd59 && $past(min) == 6'd59 && $past(hr) == 6'd23)
      |-> (hr == 6'd0 && min == 6'd0));
   assert_hold_without_step_R5: assert property (@(posedge clk) disable iff (rst || !armed)
      !$past(step) |-> ($stable(sec) && $stable(min) && $stable(hr)));
endmodule

// File: rtl/tod_dispmap.sv
module tod_dispmap
   import tod_pkg::*;
(
   input  logic [FIELD_W-1:0] hr,
   input  logic [FIELD_W-1:0] min,
   input  logic [FIELD_W-1:0] sec,
   input  logic               hour12,
   output logic [DISP_W-1:0]  digits
);
   logic [FIELD_W-1:0] hr_show;
   logic [7:0]         h2, m2, s2;

   always_comb begin
      hr_show = hr;
      if (hour12) begin
         if (hr == '0)               hr_show = FIELD_W'(12);
         else if (hr > FIELD_W'(12)) hr_show = hr - FIELD_W'(12);
      end
      assert_hour12_range_R6: assert (!hour12 || hr >= FIELD_W'(24) ||
                                      (hr_show >= FIELD_W'(1) && hr_show <= FIELD_W'(12)));
   end

   assign h2 = to_bcd2(hr_show);
   assign m2 = to_bcd2(min);
   assign s2 = to_bcd2(sec);

   // position p lives in digits[4p+3:4p]; position 0 is hour tens
   assign digits = {s2[3:0], s2[7:4], m2[3:0], m2[7:4], h2[3:0], h2[7:4]};
endmodule

// File: rtl/tod_refresh.sv
module tod_refresh
   import tod_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic [DISP_W-1:0] digits,
   output logic              strobe,
   output logic [POS_W-1:0]  pos,
   output bcd_t              bcd
);
   generate
      if ((1 << POS_W) < NUM_POS) begin : g_bad_pos
         initial $fatal(1, "tod_refresh: POS_W too narrow");
      end
   endgenerate

   localparam logic [POS_W-1:0] LAST = POS_W'(NUM_POS - 1);
   logic [POS_W-1:0] ptr;

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr    <= '0;
         pos    <= '0;
         bcd    <= '0;
         strobe <= 1'b0;
      end else begin
         strobe <= tick;
         if (tick) begin
            pos <= ptr;
            bcd <= digits[4*ptr +: 4];
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
         end
      end
   end

   logic armed;
   always_ff @(posedge clk) armed <= !rst;

   assert_strobe_after_tick_R8: assert property (@(posedge clk) disable iff (rst || !armed)
      strobe |-> $past(tick));
   assert_pos_range_R8: assert property (@(posedge clk) disable iff (rst)
      pos <= LAST);
endmodule

// File: rtl/xtal_tod_core.sv
module xtal_tod_core
   import tod_pkg::*;
#(
   parameter int PRE_W = 16
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        slow_en,
   input  logic        hour12,
   output logic        sec_tick,
   output logic [5:0]  sec_bin,
   output logic [5:0]  min_bin,
   output logic [5:0]  hr_bin,
   output logic [23:0] disp_bcd,
   output logic        dig_strobe,
   output logic [2:0]  dig_pos,
   output logic [3:0]  dig_bcd
);
   generate
      if (FIELD_W != 6 || DISP_W != 24 || POS_W != 3) begin : g_bad_pkg
         initial $fatal(1, "xtal_tod_core: package widths disagree with ports");
      end
   endgenerate

   logic step;

   tod_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk     (clk),
      .rst     (rst),
      .slow_en (slow_en),
      .step    (step),
      .tick    (sec_tick)
   );

   tod_cascade u_casc (
      .clk  (clk),
      .rst  (rst),
      .step (step),
      .sec  (sec_bin),
      .min  (min_bin),
      .hr   (hr_bin)
   );

   tod_dispmap u_map (
      .hr     (hr_bin),
      .min    (min_bin),
      .sec    (sec_bin),
      .hour12 (hour12),
      .digits (disp_bcd)
   );

   tod_refresh u_ref (
      .clk    (clk),
      .rst    (rst),
      .tick   (sec_tick),
      .digits (disp_bcd),
      .strobe (dig_strobe),
      .pos    (dig_pos),
      .bcd    (dig_bcd)
   );

   assert_reset_clear_R9: assert property (@(posedge clk)
      $past(rst) |-> (hr_bin == 6'd0 && min_bin == 6'd0 && sec_bin == 6'd0 &&
                      !sec_tick && !dig_strobe));
   assert_tick_moves_time_R3: assert property (@(posedge clk) disable iff (rst)
      sec_tick |-> (sec_bin != $past(sec_bin) || $past(rst)));
endmodule

// File: tb/sim_xtal_tod_core.sv
`timescale 1ns/1ps
module sim_xtal_tod_core;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en0 = 1'b0, en1 = 1'b0, h12 = 1'b0;

   logic        tick0, tick1, stb0, stb1;
   logic [5:0]  s0, m0, hh0, s1, m1, hh1;
   logic [23:0] d0, d1;
   logic [2:0]  p0, p1;
   logic [3:0]  b0, b1;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   xtal_tod_core u0 (
      .clk(clk), .rst(rst), .slow_en(en0), .hour12(h12), .sec_tick(tick0),
      .sec_bin(s0), .min_bin(m0), .hr_bin(hh0), .disp_bcd(d0),
      .dig_strobe(stb0), .dig_pos(p0), .dig_bcd(b0));

   xtal_tod_core #(.PRE_W(1)) u1 (
      .clk(clk), .rst(rst), .slow_en(en1), .hour12(h12), .sec_tick(tick1),
      .sec_bin(s1), .min_bin(m1), .hr_bin(hh1), .disp_bcd(d1),
      .dig_strobe(stb1), .dig_pos(p1), .dig_bcd(b1));

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [23:0] exp_disp(input int h, input int m, input int s, input bit m12);
      int hs = h;
      if (m12) begin
         if (h == 0) hs = 12;
         else if (h > 12) hs = h - 12;
      end
      return {4'(s % 10), 4'(s / 10), 4'(m % 10), 4'(m / 10), 4'(hs % 10), 4'(hs / 10)};
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; en0 = 1'b0; en1 = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic run0(input int n);
      @(negedge clk) en0 = 1'b1;
      repeat (n) @(negedge clk);
      en0 = 1'b0;
   endtask

   task automatic run1(input int n);
      @(negedge clk) en1 = 1'b1;
      repeat (n) @(negedge clk);
      en1 = 1'b0;
   endtask

   task automatic chk_time1(input string req, input int h, input int m, input int s);
      chk(hh1 == 6'(h), req, "hours", hh1, h);
      chk(m1 == 6'(m), req, "minutes", m1, m);
      chk(s1 == 6'(s), req, "seconds", s1, s);
      chk(d1 == exp_disp(h, m, s, h12), req, "display digits", d1, exp_disp(h, m, s, h12));
   endtask

   // R9: reset state
   task automatic test_reset();
      do_reset();
      @(negedge clk);
      chk(s0 == 0 && m0 == 0 && hh0 == 0, "R9", "time after reset", {hh0, m0, s0}, 0);
      chk(tick0 == 0, "R9", "tick after reset", tick0, 0);
      chk(stb0 == 0, "R9", "digit strobe after reset", stb0, 0);
      chk(d0 == 24'h0, "R9", "display after reset (24h)", d0, 0);
   endtask

   // R1, R2: default prescaler, 32768 enables per tick, reload
   task automatic test_prescaler();
      do_reset();
      h12 = 1'b0;
      run0(32767);
      chk(tick0 == 0, "R1", "tick after 32767 enables", tick0, 0);
      chk(s0 == 0, "R1", "seconds after 32767 enables", s0, 0);
      run0(1);
      chk(tick0 == 1, "R1", "tick on 32768th enable", tick0, 1);
      chk(s0 == 1, "R1", "seconds after first overflow", s0, 1);
      @(negedge clk);
      chk(tick0 == 0, "R2", "tick width one cycle", tick0, 0);
      chk(stb0 == 1 && p0 == 0 && b0 == 0, "R8", "first refresh strobe pos/value",
          {stb0, p0, b0}, {1'b1, 3'd0, 4'd0});
      run0(32767);
      chk(s0 == 1 && tick0 == 0, "R2", "no tick before second full period", s0, 1);
      run0(1);
      chk(s0 == 2 && tick0 == 1, "R2", "tick after reload period", s0, 2);
   endtask

   // R7, R8: round-robin refresh
   task automatic test_refresh();
      do_reset();
      h12 = 1'b0;
      for (int k = 1; k <= 7; k++) begin
         logic [23:0] e;
         int p;
         run1(1);
         chk(tick1 == 1 && stb1 == 0, "R8", "strobe waits one cycle after tick", stb1, 0);
         @(negedge clk);
         p = (k - 1) % 6;
         e = exp_disp(0, 0, k, 1'b0);
         chk(stb1 == 1, "R8", "refresh strobe", stb1, 1);
         chk(p1 == 3'(p), "R8", "refresh position", p1, p);
         chk(b1 == e[4*p +: 4], "R7", "refresh digit value", b1, e[4*p +: 4]);
         @(negedge clk);
         chk(stb1 == 0, "R8", "strobe one cycle", stb1, 0);
      end
      chk(d1 == exp_disp(0, 0, 7, 1'b0), "R7", "digit positions 00:00:07", d1, exp_disp(0, 0, 7, 1'b0));
   endtask

   // R3..R6: cascade and display over a full day
   task automatic test_day();
      do_reset();
      h12 = 1'b0;
      run1(59);    chk_time1("R3", 0, 0, 59);
      run1(1);     chk_time1("R3", 0, 1, 0);
      run1(3540);  chk_time1("R4", 1, 0, 0);
      run1(39600); chk_time1("R6", 12, 0, 0);
      h12 = 1'b1; #1;
      chk_time1("R6", 12, 0, 0);
      run1(3600);  chk_time1("R6", 13, 0, 0);
      chk(d1[7:0] == 8'h10, "R6", "13h shown as 01", d1[7:0], 8'h10);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk) h12 = ~h12;
         @(negedge clk);
         chk(hh1 == 13 && m1 == 0 && s1 == 0, "R5", "mode toggle keeps time",
             {hh1, m1, s1}, {6'd13, 12'd0});
      end
      h12 = 1'b0;
      run1(39599); chk_time1("R4", 23, 59, 59);
      h12 = 1'b1; #1;
      chk_time1("R6", 23, 59, 59);
      run1(1);     chk_time1("R4", 0, 0, 0);
      chk(d1[7:0] == 8'h21, "R6", "hour 0 shown as 12", d1[7:0], 8'h21);
      h12 = 1'b0; #1;
      chk(d1[7:0] == 8'h00, "R6", "hour 0 shown as 00 in 24h", d1[7:0], 0);
   endtask

   initial begin : watchdog
      int cyc = 0;
      while (!done && cyc < 195000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 195000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      test_reset();
      test_prescaler();
      test_refresh();
      test_day();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule